// File: doc/BRIEF.md
# Unaligned Load Splitter-Merger

This block sits between a load unit and a memory that holds 16-bit words, each word placed at an even byte address. The load unit asks for a byte or a word at any byte address. The block turns each request into one or two aligned word reads on the memory port. It then picks out or joins the addressed bytes and returns the value right-justified. Bytes within a word are little-endian: the even address is bits 7:0 and the odd address is bits 15:8.

A word request at an odd address needs two memory reads: first the aligned word that holds the start byte, then the next aligned word. The block keeps one byte from each read. A configuration input can turn on trap mode. In that mode, such a request does no memory read at all. Instead it ends with a fault response. Only one request can be in flight at a time. The memory returns read data exactly one cycle after a read is issued.

Top module: `ulsm_top`

## Requirements
- R1: During and after reset, with no request, `req_ready` is 1 and `resp_valid`, `resp_fault` and `mem_rd_en` are 0.
- R2: A word request (`req_size`=1) at an even address issues exactly one memory read at that address. It returns the read word unchanged with `resp_fault`=0. `resp_valid` is high in the second cycle after the accepting edge.
- R3: A byte request (`req_size`=0) issues exactly one read, at the address with bit 0 cleared. It returns the addressed byte zero-extended to 16 bits: bits 7:0 of the word for an even address, bits 15:8 for an odd one. The response arrives in the second cycle after acceptance.
- R4: With trap mode off, a word request at an odd address issues two reads in back-to-back cycles: first at the address with bit 0 cleared, then at that address plus 2. The response arrives in the third cycle after acceptance. Every memory read address is even.
- R5: The result of a split word read is {second word bits 7:0, first word bits 15:8}.
- R6: With `cfg_trap_en`=1 at acceptance, a word request at an odd address issues no memory read. It responds in the first cycle after acceptance with `resp_fault`=1 and `resp_data`=0.
- R7: `cfg_trap_en` has no effect on byte requests or on even-address word requests. These complete as in R2 and R3, with `resp_fault`=0.
- R8: `req_ready` is low from the accepting edge until the response cycle has passed. A request held on `req_valid` while busy is ignored: it causes no read and does not change the response.
- R9: `resp_valid` is a one-cycle pulse per request, and `resp_fault` is never high without `resp_valid`.
- R10: The second read address wraps at the top of the address space. A word request at 0xFFFF reads 0xFFFE and then 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| cfg_trap_en | input | 1 | 1 = fault on odd-address word requests instead of splitting |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Byte address of the request |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Response data valid (one-cycle pulse) |
| resp_data | output | 16 | Right-justified result |
| resp_fault | output | 1 | Alignment fault on this response |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Even byte address of the word to read |
| mem_rd_data | input | 16 | Read word, valid the cycle after `mem_rd_en` |

## Verification
Some rules are checked by the in-line assertions on every cycle:
- every memory read address is even;
- a second back-to-back read sits two bytes above the first, wrapping at the top;
- `resp_valid` is a single-cycle pulse;
- a fault comes only with `resp_valid`, with zero data and with no read in the cycle before;
- `req_ready` drops after each acceptance.

Other behaviour can only be shown by the bench's directed scenarios, because it depends on memory contents and on counting cycles from acceptance:
- the byte selection and the two-word splice;
- the response latency of each request kind;
- how many reads each request makes;
- that trap mode is ignored for byte and aligned requests;
- that a request held while busy has no effect.

// File: rtl/ulsm_pkg.sv
package ulsm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH1 = 2'd1,
    ST_FETCH2 = 2'd2,
    ST_RESP   = 2'd3
  } ulsm_state_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } ulsm_size_e;

endpackage

// File: rtl/ulsm_addr_gen.sv
module ulsm_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] second_o
);

  localparam int OFS_W = $clog2(WORD_BYTES);

  // Clear the in-word offset bits; the next word is one word-size higher,
  // wrapping naturally at the top of the address space.
  always_comb begin
    first_o  = {base_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    second_o = first_o + ADDR_W'(WORD_BYTES);
  end

endmodule

// File: rtl/ulsm_ctrl.sv
module ulsm_ctrl
  import ulsm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_trap_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_size,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              hold_en,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic              size_word,
  output logic              split,
  output logic              odd
);

  ulsm_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              size_q, odd_q, split_q, fault_q;
  logic              accept, req_odd_word, req_fault;
  logic [ADDR_W-1:0] first_addr, second_addr;

  assign accept       = (state_q == ST_IDLE) && req_valid;
  assign req_odd_word = (req_size == SZ_WORD) && req_addr[0];
  assign req_fault    = req_odd_word && cfg_trap_en;

  ulsm_addr_gen #(.ADDR_W(ADDR_W), .WORD_BYTES(2)) u_addr (
    .base_i  (addr_q),
    .first_o (first_addr),
    .second_o(second_addr)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = req_fault ? ST_RESP : ST_FETCH1;
      ST_FETCH1: state_d = split_q ? ST_FETCH2 : ST_RESP;
      ST_FETCH2: state_d = ST_RESP;
      ST_RESP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= 1'b0;
      odd_q   <= 1'b0;
      split_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      odd_q   <= req_addr[0];
      split_q <= req_odd_word && !cfg_trap_en;
      fault_q <= req_fault;
    end
  end

  always_comb begin
    req_ready   = (state_q == ST_IDLE);
    mem_rd_en   = (state_q == ST_FETCH1) || (state_q == ST_FETCH2);
    mem_rd_addr = (state_q == ST_FETCH2) ? second_addr : first_addr;
    hold_en     = (state_q == ST_FETCH2);
    resp_valid  = (state_q == ST_RESP);
    resp_fault  = (state_q == ST_RESP) && fault_q;
    size_word   = size_q;
    split       = split_q;
    odd         = odd_q;
  end

  p_rd_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !mem_rd_addr[0]);

  p_second_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == ADDR_W'($past(mem_rd_addr) + ADDR_W'(2))));

  p_fault_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> !$past(mem_rd_en));

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_fault_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> resp_valid);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/ulsm_merge.sv
module ulsm_merge #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_en,
  input  logic [2*BYTE_W-1:0] rd_word,
  input  logic                resp_valid,
  input  logic                resp_fault,
  input  logic                size_word,
  input  logic                split,
  input  logic                odd,
  output logic [2*BYTE_W-1:0] data_o
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] first_q;
  logic [BYTE_W-1:0] lo_b, hi_b, sel_b;

  // First word of a split read, captured as it returns from memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       first_q <= '0;
    else if (hold_en) first_q <= rd_word;
  end

  assign lo_b  = rd_word[BYTE_W-1:0];
  assign hi_b  = rd_word[WORD_W-1:BYTE_W];
  assign sel_b = odd ? hi_b : lo_b;

  always_comb begin
    data_o = '0;
    if (resp_valid && !resp_fault) begin
      if (!size_word)  data_o = {{BYTE_W{1'b0}}, sel_b};
      else if (split)  data_o = {lo_b, first_q[WORD_W-1:BYTE_W]};
      else             data_o = rd_word;
    end
  end

endmodule

// File: rtl/ulsm_top.sv
module ulsm_top #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_trap_en,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_size,
  output logic                req_ready,
  output logic                resp_valid,
  output logic [2*BYTE_W-1:0] resp_data,
  output logic                resp_fault,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic [2*BYTE_W-1:0] mem_rd_data
);

  logic hold_en, size_word, split, odd;

  ulsm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_trap_en(cfg_trap_en),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_ready  (req_ready),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .hold_en    (hold_en),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .size_word  (size_word),
    .split      (split),
    .odd        (odd)
  );

  ulsm_merge #(.BYTE_W(BYTE_W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_en   (hold_en),
    .rd_word   (mem_rd_data),
    .resp_valid(resp_valid),
    .resp_fault(resp_fault),
    .size_word (size_word),
    .split     (split),
    .odd       (odd),
    .data_o    (resp_data)
  );

  p_fault_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (resp_data == '0));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!resp_valid && !mem_rd_en));

endmodule

// File: tb/tb_ulsm_top.sv
module tb_ulsm_top;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, cfg_trap_en, req_valid, req_size;
  logic [15:0] req_addr, mem_rd_addr, mem_rd_data, resp_data;
  logic        req_ready, resp_valid, resp_fault, mem_rd_en;

  int errors = 0;
  int checks = 0;
  int fetch_cnt = 0;
  logic [15:0] fa0, fa1;
  bit done = 0;

  ulsm_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_trap_en(cfg_trap_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_fault(resp_fault), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bval(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] wval(input logic [15:0] a);
    return {bval({a[15:1], 1'b1}), bval({a[15:1], 1'b0})};
  endfunction

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= wval(mem_rd_addr);
      if (fetch_cnt == 0) fa0 <= mem_rd_addr;
      if (fetch_cnt == 1) fa1 <= mem_rd_addr;
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input bit sz, input bit trap,
                         input logic [15:0] exp_d, input bit exp_f,
                         input int exp_lat, input int exp_fetch, input string tag);
    int lat;
    @(negedge clk);
    fetch_cnt = 0;
    cfg_trap_en = trap; req_valid = 1'b1; req_addr = a; req_size = sz;
    chk(req_ready === 1'b1, {tag, " ready"}, req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (resp_valid !== 1'b1 && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    chk(resp_data === exp_d, {tag, " data"}, resp_data, exp_d);
    chk(resp_fault === exp_f, {tag, " fault"}, resp_fault, exp_f);
    chk(fetch_cnt == exp_fetch, {tag, " read count"}, fetch_cnt, exp_fetch);
    @(negedge clk);
    chk(resp_valid === 1'b0 && resp_fault === 1'b0, {tag, " R9 pulse"}, {resp_valid, resp_fault}, 0);
    chk(req_ready === 1'b1, {tag, " R8 ready back"}, req_ready, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_trap_en = 0; req_valid = 0; req_addr = 0; req_size = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready in reset", req_ready, 1);
    chk(resp_valid === 1'b0 && resp_fault === 1'b0, "R1 resp in reset", {resp_valid, resp_fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rd_en === 1'b0 && req_ready === 1'b1, "R1 idle after reset", {mem_rd_en, req_ready}, 1);
  endtask

  task automatic t_aligned_word;
    do_read(16'h1234, 1, 0, wval(16'h1234), 0, 2, 1, "R2 even word");
    chk(fa0 == 16'h1234, "R2 read address", fa0, 16'h1234);
    do_read(16'h0000, 1, 0, wval(16'h0000), 0, 2, 1, "R2 word at zero");
  endtask

  task automatic t_byte_reads;
    do_read(16'h4A20, 0, 0, {8'h00, bval(16'h4A20)}, 0, 2, 1, "R3 even byte");
    do_read(16'h4A21, 0, 0, {8'h00, bval(16'h4A21)}, 0, 2, 1, "R3 odd byte");
    chk(fa0 == 16'h4A20, "R3 odd byte read address", fa0, 16'h4A20);
  endtask

  task automatic t_split_word;
    logic [15:0] w1, w2;
    w1 = wval(16'h0F36); w2 = wval(16'h0F38);
    do_read(16'h0F37, 1, 0, {w2[7:0], w1[15:8]}, 0, 3, 2, "R4 R5 odd word split");
    chk(fa0 == 16'h0F36, "R4 first read address", fa0, 16'h0F36);
    chk(fa1 == 16'h0F38, "R4 second read address", fa1, 16'h0F38);
  endtask

  task automatic t_trap;
    do_read(16'h2221, 1, 1, 16'h0000, 1, 1, 0, "R6 trapped odd word");
  endtask

  task automatic t_trap_ignored;
    do_read(16'h3330, 1, 1, wval(16'h3330), 0, 2, 1, "R7 trap even word");
    do_read(16'h3331, 0, 1, {8'h00, bval(16'h3331)}, 0, 2, 1, "R7 trap odd byte");
  endtask

  task automatic t_busy_ignored;
    logic [15:0] w1, w2;
    int lat;
    bit ready_seen;
    w1 = wval(16'h5550); w2 = wval(16'h5552);
    @(negedge clk);
    fetch_cnt = 0; cfg_trap_en = 0;
    req_valid = 1; req_addr = 16'h5551; req_size = 1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 16'h7770; req_size = 0; // held while busy
    lat = 1; ready_seen = 0;
    while (resp_valid !== 1'b1 && lat < 10) begin
      if (req_ready !== 1'b0) ready_seen = 1;
      @(negedge clk);
      lat++;
    end
    if (req_ready !== 1'b0) ready_seen = 1;
    req_valid = 0;
    chk(!ready_seen, "R8 ready low while busy", ready_seen, 0);
    chk(resp_data === {w2[7:0], w1[15:8]}, "R8 data unaffected", resp_data, {w2[7:0], w1[15:8]});
    chk(fetch_cnt == 2, "R8 no extra reads", fetch_cnt, 2);
    @(negedge clk);
    chk(resp_valid === 1'b0 && fetch_cnt == 2, "R8 held request not taken", {resp_valid, 8'(fetch_cnt)}, 2);
  endtask

  task automatic t_wrap;
    logic [15:0] w1, w2;
    w1 = wval(16'hFFFE); w2 = wval(16'h0000);
    do_read(16'hFFFF, 1, 0, {w2[7:0], w1[15:8]}, 0, 3, 2, "R10 wrap split");
    chk(fa0 == 16'hFFFE, "R10 first address", fa0, 16'hFFFE);
    chk(fa1 == 16'h0000, "R10 wrapped address", fa1, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_aligned_word();
    t_byte_reads();
    t_split_word();
    t_trap();
    t_trap_ignored();
    t_busy_ignored();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule